// File: doc/BRIEF.md
# Serviced Watchdog Timer

The block is a watchdog timer. Software configures and services it through a small 16-bit register port with a simple strobe/cycle/acknowledge handshake. A down-counter takes its start value from a programmable timeout register. It counts one step for every rising edge of a slow oscillator input. That input is synchronised into the bus clock domain before use.

If software does not restart the counter in time, the counter runs out. The block then sets a sticky event flag, pulses a reset request, and can raise an interrupt. Software restarts the counter by writing two fixed service words, one after the other, to the count register. The configuration is guarded in three stages:
- the running enable freezes the mode bits and the timeout;
- a protect bit freezes the enable;
- a lock bit freezes the protect bit until the next reset.

Three low-power mode inputs can pause the count, unless software has allowed counting in that mode.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the control word (offset 0) reads 0x0004, the timeout (offset 1) reads 0xFFFF, the count (offset 2) reads 0xFFFF, and irq_o and rst_req_o are low.
- R2: Each access with strobe and cycle both high is acknowledged by a one-cycle bus_ack_o in the following clock cycle. Word offsets are 0 for control, 1 for timeout and 2 for count. A read returns the current value of the register.
- R3: A write that changes control bit 2 (enable) from 0 to 1 loads the count from the timeout. Each synchronised rising edge of osc_i then lowers the count by one. Clearing the enable and setting it again reloads the count.
- R4: While enable is set, writes to the timeout are discarded and control bits 3 (run in wait), 4 (run in stop) and 5 (run in debug) keep their values. While enable is clear, these bits and the timeout can be written.
- R5: While control bit 1 (protect) is set, a write cannot change the enable bit.
- R6: While control bit 0 (lock) is set, the protect bit cannot change. Lock is set by writing 1, and only a reset clears it.
- R7: Ordinary writes to the count register are ignored. Writing SVC_WORD_A (0x5555) and then SVC_WORD_B (0xAAAA) reloads the count from the timeout and clears the event flag.
- R8: If any other value is written to the count register between the two service words, the sequence is cancelled and no reload happens.
- R9: An oscillator edge that finds the count at zero sets control bit 8 (event) and reloads the count from the timeout. Writing control with bit 8 set clears the event.
- R10: Each expiry drives rst_req_o high for exactly one clock cycle.
- R11: irq_o is high while the event flag is set and at least one of control bits 7:6 (interrupt enable) is set.
- R12: While wait_mode_i, stop_mode_i or debug_mode_i is high, counting pauses unless the matching run bit (3, 4 or 5) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_adr_i | input | 2 | Register word offset |
| bus_dat_i | input | 16 | Write data |
| bus_dat_o | output | 16 | Read data |
| bus_we_i | input | 1 | Write enable |
| bus_stb_i | input | 1 | Strobe |
| bus_cyc_i | input | 1 | Bus cycle |
| bus_ack_o | output | 1 | Acknowledge |
| osc_i | input | 1 | Slow oscillator, asynchronous |
| wait_mode_i | input | 1 | System wait mode |
| stop_mode_i | input | 1 | System stop mode |
| debug_mode_i | input | 1 | System debug mode |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest state to reach from the ports is a lock that is set and then released. Once lock and protect are both set, no write sequence can clear them, so the bench must pulse the reset input in the middle of the run and read the control word again.

Expiry is also indirect. It needs a counted number of oscillator pulses from a known loaded value. The bench therefore programs small timeouts and emits exact pulse trains, each pulse several bus clocks wide so that it passes the synchroniser. It also counts rst_req_o samples to prove the pulse is one cycle wide.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DW = 16;

    localparam logic [1:0] OFS_CTL  = 2'd0;
    localparam logic [1:0] OFS_TOUT = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;

    // Packed order equals bit position in the control word (bit 8 down to 0)
    typedef struct packed {
        logic       evt;
        logic [1:0] ie;
        logic       run_dbg;
        logic       run_stop;
        logic       run_wait;
        logic       en;
        logic       wp;
        logic       lock;
    } wdg_ctl_t;

    localparam int CTLW = $bits(wdg_ctl_t);

    typedef struct packed {
        wdg_ctl_t          ctl;
        logic [DW-1:0]     tout;
        logic [DW-1:0]     cnt;
        logic              armed;
        logic              rst_req;
    } wdg_state_t;

    localparam wdg_ctl_t CTL_RST = '{evt: 1'b0, ie: 2'b00, run_dbg: 1'b0,
                                     run_stop: 1'b0, run_wait: 1'b0,
                                     en: 1'b1, wp: 1'b0, lock: 1'b0};

    localparam wdg_state_t ST_RST = '{ctl: CTL_RST, tout: '1, cnt: '1,
                                      armed: 1'b0, rst_req: 1'b0};

endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // last synchronised stage high, history stage low
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/wdg_bus_port.sv
module wdg_bus_port #(
    parameter int AW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          stb_i,
    input  logic          cyc_i,
    input  logic          we_i,
    input  logic [AW-1:0] adr_i,
    output logic          ack_o,
    output logic          wr_ctl_o,
    output logic          wr_tout_o,
    output logic          wr_cnt_o
);
    import wdg_pkg::*;

    logic ack_d, ack_q;
    logic start;

    always_comb begin
        start = stb_i & cyc_i & ~ack_q;
        ack_d = start;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= 1'b0;
        else         ack_q <= ack_d;
    end

    assign ack_o     = ack_q;
    assign wr_ctl_o  = start & we_i & (adr_i == AW'(OFS_CTL));
    assign wr_tout_o = start & we_i & (adr_i == AW'(OFS_TOUT));
    assign wr_cnt_o  = start & we_i & (adr_i == AW'(OFS_CNT));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
    parameter int                    ADDR_W      = 2,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [wdg_pkg::DW-1:0] SVC_WORD_A = 16'h5555,
    parameter logic [wdg_pkg::DW-1:0] SVC_WORD_B = 16'hAAAA
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [ADDR_W-1:0]       bus_adr_i,
    input  logic [wdg_pkg::DW-1:0]  bus_dat_i,
    output logic [wdg_pkg::DW-1:0]  bus_dat_o,
    input  logic                    bus_we_i,
    input  logic                    bus_stb_i,
    input  logic                    bus_cyc_i,
    output logic                    bus_ack_o,
    input  logic                    osc_i,
    input  logic                    wait_mode_i,
    input  logic                    stop_mode_i,
    input  logic                    debug_mode_i,
    output logic                    irq_o,
    output logic                    rst_req_o
);
    import wdg_pkg::*;

    wdg_state_t st_d, st_q;

    logic wr_ctl, wr_tout, wr_cnt;
    logic osc_rise;
    logic run_ok, tick, reload, evt_clr;

    wdg_bus_port #(.AW(ADDR_W)) u_port (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stb_i     (bus_stb_i),
        .cyc_i     (bus_cyc_i),
        .we_i      (bus_we_i),
        .adr_i     (bus_adr_i),
        .ack_o     (bus_ack_o),
        .wr_ctl_o  (wr_ctl),
        .wr_tout_o (wr_tout),
        .wr_cnt_o  (wr_cnt)
    );

    wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (osc_i),
        .rise_o  (osc_rise)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        reload       = 1'b0;
        evt_clr      = 1'b0;

        run_ok = ~(wait_mode_i  & ~st_q.ctl.run_wait)
               & ~(stop_mode_i  & ~st_q.ctl.run_stop)
               & ~(debug_mode_i & ~st_q.ctl.run_dbg);
        tick   = osc_rise & st_q.ctl.en & run_ok;

        if (wr_ctl) begin
            st_d.ctl.lock = st_q.ctl.lock | bus_dat_i[0];
            if (!st_q.ctl.lock) st_d.ctl.wp = bus_dat_i[1];
            if (!st_q.ctl.wp)   st_d.ctl.en = bus_dat_i[2];
            if (!st_q.ctl.en) begin
                st_d.ctl.run_wait = bus_dat_i[3];
                st_d.ctl.run_stop = bus_dat_i[4];
                st_d.ctl.run_dbg  = bus_dat_i[5];
            end
            st_d.ctl.ie = bus_dat_i[7:6];
            evt_clr     = bus_dat_i[8];
            reload      = ~st_q.ctl.en & st_d.ctl.en;
        end

        if (wr_tout && !st_q.ctl.en) st_d.tout = bus_dat_i;

        if (wr_cnt) begin
            if (bus_dat_i == SVC_WORD_A) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed && bus_dat_i == SVC_WORD_B) begin
                st_d.armed = 1'b0;
                reload     = 1'b1;
                evt_clr    = 1'b1;
            end else begin
                st_d.armed = 1'b0;
            end
        end

        if (evt_clr) st_d.ctl.evt = 1'b0;

        if (reload) begin
            st_d.cnt = st_q.tout;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt     = st_q.tout;
                st_d.ctl.evt = 1'b1;
                st_d.rst_req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RST;
        else         st_q <= st_d;
    end

    always_comb begin
        case (bus_adr_i)
            ADDR_W'(OFS_CTL):  bus_dat_o = {{(DW-CTLW){1'b0}}, st_q.ctl};
            ADDR_W'(OFS_TOUT): bus_dat_o = st_q.tout;
            ADDR_W'(OFS_CNT):  bus_dat_o = st_q.cnt;
            default:           bus_dat_o = '0;
        endcase
    end

    assign irq_o     = st_q.ctl.evt & (|st_q.ctl.ie);
    assign rst_req_o = st_q.rst_req;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                stb_i,
    input logic                cyc_i,
    input logic                ack_i,
    input logic                irq_i,
    input logic                rst_req_i,
    input wdg_pkg::wdg_state_t st_i
);

    p_ack_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && cyc_i && !ack_i) |=> ack_i);

    p_tout_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_i.ctl.en |=> (st_i.tout == $past(st_i.tout)));

    p_en_pinned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_i.ctl.wp |=> (st_i.ctl.en == $past(st_i.ctl.en)));

    p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_i.ctl.lock |=> st_i.ctl.lock);

    p_wp_pinned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_i.ctl.lock |=> (st_i.ctl.wp == $past(st_i.ctl.wp)));

    p_req_sets_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |-> st_i.ctl.evt);

    p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |=> !rst_req_i);

    p_irq_needs_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> st_i.ctl.evt);

endmodule

bind svc_watchdog wdg_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (bus_stb_i),
    .cyc_i     (bus_cyc_i),
    .ack_i     (bus_ack_o),
    .irq_i     (irq_o),
    .rst_req_i (rst_req_o),
    .st_i      (st_q)
);

// File: tb/tb_svc_watchdog.sv
`timescale 1ns/1ps
module tb_svc_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  adr = '0;
    logic [15:0] wdat = '0;
    logic [15:0] rdat;
    logic        we = 1'b0, stb = 1'b0, cyc = 1'b0;
    logic        ack;
    logic        osc = 1'b0;
    logic        wmode = 1'b0, smode = 1'b0, dmode = 1'b0;
    logic        irq, rreq;

    int n_tests = 0;
    int n_fail  = 0;
    int req_pulses = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    svc_watchdog dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_adr_i    (adr),
        .bus_dat_i    (wdat),
        .bus_dat_o    (rdat),
        .bus_we_i     (we),
        .bus_stb_i    (stb),
        .bus_cyc_i    (cyc),
        .bus_ack_o    (ack),
        .osc_i        (osc),
        .wait_mode_i  (wmode),
        .stop_mode_i  (smode),
        .debug_mode_i (dmode),
        .irq_o        (irq),
        .rst_req_o    (rreq)
    );

    always @(negedge clk) if (rreq) req_pulses++;

    localparam logic [1:0] OW = 2'd0, OR = 2'd1, OO = 2'd2;
    localparam int NV = 58;
    // {req, op, offset, data or pulse count, expected}
    localparam logic [39:0] VEC [NV] = '{
        {4'd1, OR, 2'd0, 16'h0000, 16'h0004},   // R1
        {4'd1, OR, 2'd1, 16'h0000, 16'hFFFF},
        {4'd1, OR, 2'd2, 16'h0000, 16'hFFFF},
        {4'd4, OW, 2'd0, 16'h0000, 16'h0000},
        {4'd2, OW, 2'd1, 16'h0005, 16'h0000},   // R2
        {4'd2, OR, 2'd1, 16'h0000, 16'h0005},
        {4'd3, OW, 2'd0, 16'h0004, 16'h0000},   // R3 load
        {4'd3, OR, 2'd2, 16'h0000, 16'h0005},
        {4'd3, OO, 2'd0, 16'd2,    16'h0000},
        {4'd3, OR, 2'd2, 16'h0000, 16'h0003},
        {4'd4, OW, 2'd1, 16'h1234, 16'h0000},   // R4 discarded
        {4'd4, OR, 2'd1, 16'h0000, 16'h0005},
        {4'd4, OW, 2'd0, 16'h003C, 16'h0000},
        {4'd4, OR, 2'd0, 16'h0000, 16'h0004},
        {4'd7, OW, 2'd2, 16'h0000, 16'h0000},   // R7 plain write
        {4'd7, OR, 2'd2, 16'h0000, 16'h0003},
        {4'd7, OW, 2'd2, 16'h5555, 16'h0000},
        {4'd7, OW, 2'd2, 16'hAAAA, 16'h0000},
        {4'd7, OR, 2'd2, 16'h0000, 16'h0005},
        {4'd3, OO, 2'd0, 16'd1,    16'h0000},
        {4'd8, OW, 2'd2, 16'h5555, 16'h0000},   // R8 cancel
        {4'd8, OW, 2'd2, 16'h1111, 16'h0000},
        {4'd8, OW, 2'd2, 16'hAAAA, 16'h0000},
        {4'd8, OR, 2'd2, 16'h0000, 16'h0004},
        {4'd9, OO, 2'd0, 16'd4,    16'h0000},   // R9 down to zero
        {4'd9, OR, 2'd2, 16'h0000, 16'h0000},
        {4'd9, OO, 2'd0, 16'd1,    16'h0000},
        {4'd9, OR, 2'd0, 16'h0000, 16'h0104},
        {4'd9, OR, 2'd2, 16'h0000, 16'h0005},
        {4'd9, OW, 2'd0, 16'h0104, 16'h0000},
        {4'd9, OR, 2'd0, 16'h0000, 16'h0004},
        {4'd9, OO, 2'd0, 16'd6,    16'h0000},
        {4'd9, OR, 2'd0, 16'h0000, 16'h0104},
        {4'd7, OW, 2'd2, 16'h5555, 16'h0000},   // R7 clears flag
        {4'd7, OW, 2'd2, 16'hAAAA, 16'h0000},
        {4'd7, OR, 2'd0, 16'h0000, 16'h0004},
        {4'd3, OO, 2'd0, 16'd2,    16'h0000},   // R3 toggle reload
        {4'd3, OW, 2'd0, 16'h0000, 16'h0000},
        {4'd3, OW, 2'd0, 16'h0004, 16'h0000},
        {4'd3, OR, 2'd2, 16'h0000, 16'h0005},
        {4'd5, OW, 2'd0, 16'h0006, 16'h0000},   // R5
        {4'd5, OR, 2'd0, 16'h0000, 16'h0006},
        {4'd5, OW, 2'd0, 16'h0002, 16'h0000},
        {4'd5, OR, 2'd0, 16'h0000, 16'h0006},
        {4'd5, OW, 2'd0, 16'h0000, 16'h0000},
        {4'd5, OR, 2'd0, 16'h0000, 16'h0004},
        {4'd5, OW, 2'd0, 16'h0000, 16'h0000},
        {4'd5, OR, 2'd0, 16'h0000, 16'h0000},
        {4'd4, OW, 2'd0, 16'h0038, 16'h0000},   // R4 writable when off
        {4'd4, OR, 2'd0, 16'h0000, 16'h0038},
        {4'd4, OW, 2'd1, 16'h0077, 16'h0000},
        {4'd4, OR, 2'd1, 16'h0000, 16'h0077},
        {4'd6, OW, 2'd0, 16'h0003, 16'h0000},   // R6
        {4'd6, OR, 2'd0, 16'h0000, 16'h0003},
        {4'd6, OW, 2'd0, 16'h0000, 16'h0000},
        {4'd6, OR, 2'd0, 16'h0000, 16'h0003},
        {4'd6, OW, 2'd0, 16'h0006, 16'h0000},
        {4'd6, OR, 2'd0, 16'h0000, 16'h0003}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [1:0] a, input logic [15:0] d,
                       output logic [15:0] r);
        @(negedge clk);
        we = w; adr = a; wdat = d; stb = 1'b1; cyc = 1'b1;
        @(negedge clk);
        check("R2 ack", {15'd0, ack}, 16'd1);
        r = rdat;
        stb = 1'b0; cyc = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R2 ack drop", {15'd0, ack}, 16'd0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        logic [15:0] dummy;
        bus(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus(1'b0, a, 16'h0, v);
        check(tag, v, exp);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            osc = 1'b1;
            repeat (3) @(negedge clk);
            osc = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 rst_req", {15'd0, rreq}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] e;
            logic [15:0] v;
            string tag;
            e = VEC[i];
            tag = $sformatf("R%0d row %0d", e[39:36], i);
            case (e[35:34])
                OW: bus(1'b1, e[33:32], e[31:16], v);
                OR: begin
                    bus(1'b0, e[33:32], 16'h0, v);
                    check(tag, v, e[15:0]);
                end
                default: pulses(int'(e[31:16]));
            endcase
        end

        // R6: only reset releases the lock
        do_reset();
        rd_chk("R6 lock cleared by reset", 2'd0, 16'h0004);
        rd_chk("R1 timeout after reset", 2'd1, 16'hFFFF);
        check("R1 irq after reset", {15'd0, irq}, 16'd0);

        // R12: mode gating
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0010);
        wr(2'd0, 16'h0008);
        wr(2'd0, 16'h000C);
        rd_chk("R12 loaded", 2'd2, 16'h0010);
        smode = 1'b1;
        pulses(2);
        rd_chk("R12 stop pauses", 2'd2, 16'h0010);
        smode = 1'b0; wmode = 1'b1;
        pulses(2);
        rd_chk("R12 wait allowed", 2'd2, 16'h000E);
        dmode = 1'b1;
        pulses(1);
        rd_chk("R12 debug pauses", 2'd2, 16'h000E);
        wmode = 1'b0; dmode = 1'b0;

        // R10 and R11: expiry outputs
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0002);
        wr(2'd0, 16'h0044);
        base = req_pulses;
        pulses(3);
        check("R11 irq with enable", {15'd0, irq}, 16'd1);
        check("R10 one-cycle request", 16'(req_pulses - base), 16'd1);
        rd_chk("R9 flag set", 2'd0, 16'h0144);
        wr(2'd0, 16'h0144);
        check("R11 irq after clear", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h0004);
        pulses(3);
        rd_chk("R9 flag again", 2'd0, 16'h0104);
        check("R11 irq masked", {15'd0, irq}, 16'd0);
        check("R10 second request", 16'(req_pulses - base), 16'd2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule